// File: doc/BRIEF.md
# Timer Interrupt Enable and Pending Register

This block gathers expiry events from a bank of timer channels and presents them as one control word with a matching set of interrupt lines. The low field of the word holds a per-channel interrupt enable. The field directly above it holds a per-channel pending flag. A channel's pending flag is set by each of its expiry events, whether or not the channel is enabled.

Software updates the word with a single write strobe and data. The enable field is replaced by the written value. Pending flags follow write-one-to-clear rules. Each channel's interrupt line rises on an expiry event only if that channel is enabled at the time. The line stays high until software clears the channel's pending flag. Changing an enable bit on its own never raises or drops a line.

All state is registered. Read data and interrupt lines reflect an event or a write from the clock edge that captures it.

Top module: `tmr_irq_stat`

## Requirements
- R1: While reset is asserted and after it is released, with no write or event, rd_data_o reads 0 and every irq_o line is 0.
- R2: On a write, the enable of channel n (bit n, n = 0..4) takes wr_data_i[n] and reads back from the next cycle.
- R3: An expiry event on evt_i[n] sets the pending flag at bit n+5 from the next cycle, whether or not enable n is set.
- R4: An event on channel n raises irq_o[n] in the next cycle if enable n was set before that edge. If enable n was clear, the event does not raise irq_o[n].
- R5: A write with wr_data_i[n+5] = 1 clears pending flag n. A pending flag written as 0 keeps its value.
- R6: When pending flag n is cleared, irq_o[n] is 0 from the same cycle as the cleared flag.
- R7: If an event and a clearing write hit the same channel in one cycle, the pending flag stays set. If the channel is enabled, its line is high in the next cycle.
- R8: Read bits 31:10 are always 0. Write data in bits 31:10 has no effect on any read bit or line.
- R9: Setting or clearing an enable bit without an event leaves irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data: enables in [4:0], clear mask in [9:5] |
| evt_i | input | 5 | Per-channel expiry event pulses |
| rd_data_o | output | 32 | Register contents: enables in [4:0], pending in [9:5], zero above |
| irq_o | output | 5 | Per-channel interrupt lines |

## Verification
The assertions inside each channel cell check the following on every cycle:
- A raised line always has its pending flag set.
- Events always set the flag.
- An enabled event always raises the line.
- A clearing write without an event empties the flag.
- Enables load from the write data.
- A line never rises without an enabled event.

The bench's scenarios are needed to show how channels interact through the shared word:
- Enabling a channel that already has a pending flag raises nothing.
- Disabling a channel whose line is high keeps the line up.
- An event wins over a same-cycle clear.
- Upper data bits are ignored.

Seeded mixed traffic compares the whole word against a model on every clock.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned DEF_N_CH   = 5;
  localparam int unsigned DEF_DATA_W = 32;

  // bit index of the pending flag for channel ch
  function automatic int unsigned pend_pos(input int unsigned n_ch, input int unsigned ch);
    return n_ch + ch;
  endfunction

  typedef struct packed {
    logic en;
    logic pend;
    logic irq;
  } chan_state_t;
endpackage

// File: rtl/tmr_irq_cell.sv
module tmr_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_en_bit_i,
  input  logic wr_clr_bit_i,
  input  logic evt_i,
  output tmr_irq_pkg::chan_state_t st_o
);
  import tmr_irq_pkg::*;

  logic en_q, pend_q, irq_q;
  logic clr;

  assign clr = wr_i & wr_clr_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_i) en_q <= wr_en_bit_i;
      // event wins over a same-cycle clear
      pend_q <= evt_i | (pend_q & ~clr);
      if (evt_i && en_q)        irq_q <= 1'b1;
      else if (clr && !evt_i)   irq_q <= 1'b0;
    end
  end

  assign st_o = '{en: en_q, pend: pend_q, irq: irq_q};

  assert_irq_has_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> pend_q);

  assert_evt_sets_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_q);

  assert_en_evt_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && en_q) |=> irq_q);

  assert_clear_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !evt_i) |=> !pend_q);

  assert_en_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_q == $past(wr_en_bit_i)));

  assert_evt_clr_race_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && clr) |=> pend_q);

  assert_no_spurious_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_q ##1 irq_q |-> $past(evt_i && en_q));
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat #(
  parameter int unsigned N_CH   = tmr_irq_pkg::DEF_N_CH,
  parameter int unsigned DATA_W = tmr_irq_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_CH-1:0]   evt_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_CH-1:0]   irq_o
);
  import tmr_irq_pkg::*;

  localparam int unsigned USED_W = 2 * N_CH;

  chan_state_t st [N_CH];
  logic [N_CH-1:0] en_vec, pend_vec;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_irq_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (wr_i),
      .wr_en_bit_i  (wr_data_i[c]),
      .wr_clr_bit_i (wr_data_i[pend_pos(N_CH, c)]),
      .evt_i        (evt_i[c]),
      .st_o         (st[c])
    );
    assign en_vec[c]   = st[c].en;
    assign pend_vec[c] = st[c].pend;
    assign irq_o[c]    = st[c].irq;
  end

  if (DATA_W > USED_W) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^wr_data_i[DATA_W-1:USED_W];
    assign rd_data_o = {{(DATA_W-USED_W){1'b0}}, pend_vec, en_vec};
  end else begin : g_nopad
    assign rd_data_o = {pend_vec, en_vec};
  end
endmodule

// File: tb/sim_tmr_irq_stat.sv
module sim_tmr_irq_stat;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [4:0]  evt = '0;
  logic [31:0] rd;
  logic [4:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit m_en[5], m_pend[5], m_irq[5];

  always #10 clk = ~clk;

  tmr_irq_stat u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .wr_data_i(wdata),
    .evt_i(evt), .rd_data_o(rd), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    for (int i = 0; i < 5; i++) begin
      v[i]     = m_en[i];
      v[i + 5] = m_pend[i];
    end
    return v;
  endfunction

  function automatic logic [4:0] exp_irq();
    logic [4:0] v;
    for (int i = 0; i < 5; i++) v[i] = m_irq[i];
    return v;
  endfunction

  task automatic compare(input string tag);
    n_chk++;
    if (rd !== exp_rd()) begin
      n_bad++;
      $display("FAIL %s rd_data_o actual=%h expected=%h", tag, rd, exp_rd());
    end
    n_chk++;
    if (irq !== exp_irq()) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", tag, irq, exp_irq());
    end
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [4:0] e, input string tag);
    wr = w; wdata = d; evt = e;
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      bit clr;
      bit ev;
      clr = w && d[i + 5];
      ev  = e[i];
      if (ev && m_en[i])   m_irq[i] = 1'b1;
      else if (clr && !ev) m_irq[i] = 1'b0;
      m_pend[i] = ev || (m_pend[i] && !clr);
      if (w) m_en[i] = d[i];
    end
    @(negedge clk);
    wr = 1'b0; wdata = '0; evt = '0;
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      m_en[i] = 0; m_pend[i] = 0; m_irq[i] = 0;
    end
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    step(0, 32'h0, 5'h00, "R1 idle");

    step(1, 32'h0000_0015, 5'h00, "R2 enables 10101");
    step(0, 32'h0, 5'b00010, "R3 event on disabled ch1");
    step(0, 32'h0, 5'b00001, "R4 event on enabled ch0");
    step(1, 32'h0000_0017, 5'h00, "R9 enable ch1 while pending");
    step(1, 32'h0000_0037, 5'h00, "R5 R6 clear ch0 keep ch1");
    step(0, 32'h0, 5'b00100, "R4 event on ch2");
    step(1, 32'h0000_0097, 5'b00100, "R7 event and clear ch2");
    step(1, 32'h0000_0013, 5'h00, "R9 disable ch2 with line high");
    step(1, 32'h0000_0093, 5'h00, "R6 clear disabled ch2");
    step(0, 32'h0, 5'b11111, "R3 events all");
    step(1, 32'hFFFF_FC00, 5'h00, "R8 upper bits only");
    step(1, 32'hFFFF_FFFF, 5'h00, "R8 all ones");
    step(1, 32'h0000_03E0, 5'h00, "R5 clear all");

    for (int k = 0; k < 400; k++) begin
      logic w;
      logic [31:0] d;
      logic [4:0] e;
      w = ($urandom % 3) == 0;
      d = $urandom;
      e = 5'($urandom & $urandom);
      step(w, d, e, "R2 R3 R4 R5 R7 mixed");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule